// File: doc/BRIEF.md
# Three-Level Interrupt Arbiter

This block sits between thirteen interrupt request sources and a small processor core. Each cycle it qualifies every source, picks one winner and registers it. A qualified source has a raised flag, its own enable set, and the global enable set. The winner is chosen first by priority level and then by a fixed rank. The block shows the winner to the core as a request line plus an 8-bit vector address. Source 0 is the wakeup source. It always sits on a dedicated top level. Every other source is placed on a high or a low level by its own level bit.

When the core acknowledges a pending request, the block marks the winner's level as in service. It clears the highest marked level when the core signals a return from a handler. While any level is in service, only requests on a strictly higher level are offered to the core. Requests on the same level or a lower level wait until the return pulses have cleared the levels above them. Clearing the flags in the peripherals is the job of the handlers.

Top module: `irq_level_arbiter`

## Requirements
- R1: While reset is asserted and after its release, `irq_req` is 0 and no level is in service. With no acknowledge given, the first qualified request of any level is offered to the core.
- R2: Source `s` takes part in arbitration only when (`flag_a[s]` or `flag_b[s]`), `src_en[s]` and `glb_en` are all 1. Either flag alone is enough.
- R3: A pending source on a higher level always beats one on a lower level, whatever their ranks. The level order from highest to lowest is top, high, low.
- R4: Among pending sources on the same level, the one with the lower bit index (rank) wins.
- R5: The vector offered for source index s is 0x33 for s=0, 8*s-5 for s=1..6 (0x03..0x2B), and 8*s+3 for s=7..12 (0x3B..0x63).
- R6: Source 0 is always on the top level and ignores `lvl_hi[0]`. Any other source is on the high level when `lvl_hi[s]`=1 and on the low level when it is 0.
- R7: `irq_req` and `irq_vec` show the winner of the inputs sampled at the previous clock edge. They are re-evaluated every cycle, so before an acknowledge a newly arrived better request replaces the one offered.
- R8: An `ack` while `irq_req` is 1 marks the offered level as in service. In the cycle after the acknowledge edge, `irq_req` is 0 unless a strictly higher level is pending, even if the served flag is still raised.
- R9: While a level is in service, requests on that level or below are not offered. A request on a strictly higher level, including the wakeup source over a high-level handler, is offered.
- R10: A `reti` pulse clears only the highest in-service level. The next cycle's offer already uses the reduced set, so a waiting request on the level below is offered only once every level above it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_a | input | 13 | First request flag per source, bit index = rank |
| flag_b | input | 13 | Second request flag per source, ORed with the first |
| src_en | input | 13 | Per-source enable |
| lvl_hi | input | 13 | Per-source level select, 1 = high, 0 = low (bit 0 unused) |
| glb_en | input | 1 | Global enable for all sources |
| ack | input | 1 | Core acknowledges the offered request |
| reti | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Vector address of the offered request |

## Verification
The bench builds the block with its default of thirteen sources and 8-bit vectors. This small source count makes a full sweep practical: every ordered pair of sources, under all four level-bit combinations, is tried with one source driven through each flag input. That sweep covers every level-versus-rank conflict and every vector value. Directed sequences then acknowledge and return through all three levels. They show that requests wait on the same or a lower level, that strictly higher levels preempt, and that each return unlocks the level below in turn.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_SRC_DEF = 13;
  localparam int VEC_W_DEF   = 8;
  localparam int NUM_LVL     = 3;
  localparam int LVL_W       = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_TOP  = 2'd2
  } irq_lvl_e;

  // Vector address for a source rank; two linear runs with a gap at 0x33.
  function automatic logic [7:0] rank_vector(input int unsigned rank);
    if (rank == 0)      return 8'h33;
    else if (rank < 7)  return 8'(8 * rank - 5);
    else                return 8'(8 * rank + 3);
  endfunction
endpackage

// File: rtl/irq_src_qualify.sv
module irq_src_qualify
  import irq_arb_pkg::*;
#(
  parameter int N        = NUM_SRC_DEF,
  parameter int WAKE_IDX = 0
) (
  input  logic [N-1:0]            flag_a,
  input  logic [N-1:0]            flag_b,
  input  logic [N-1:0]            src_en,
  input  logic [N-1:0]            lvl_hi,
  input  logic                    glb_en,
  output logic [N-1:0]            pend,
  output logic [N-1:0][LVL_W-1:0] src_lvl
);
  logic unused_wake_hi;
  assign unused_wake_hi = &{1'b0, lvl_hi[WAKE_IDX]};

  for (genvar g = 0; g < N; g++) begin : g_src
    assign pend[g] = (flag_a[g] | flag_b[g]) & src_en[g] & glb_en;
    if (g == WAKE_IDX) begin : g_wake
      assign src_lvl[g] = LVL_TOP;
    end else begin : g_norm
      assign src_lvl[g] = lvl_hi[g] ? LVL_HIGH : LVL_LOW;
    end
  end
endmodule

// File: rtl/irq_rank_select.sv
module irq_rank_select
  import irq_arb_pkg::*;
#(
  parameter int N     = NUM_SRC_DEF,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            pend,
  input  logic [N-1:0][LVL_W-1:0] src_lvl,
  input  logic [NUM_LVL-1:0]      lvl_ok,
  output logic                    win_any,
  output logic [IDX_W-1:0]        win_idx,
  output logic [LVL_W-1:0]        win_lvl
);
  logic [NUM_LVL-1:0][N-1:0]     lvl_mask;
  logic [NUM_LVL-1:0][IDX_W-1:0] lvl_idx;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar s = 0; s < N; s++) begin : g_m
      assign lvl_mask[l][s] = pend[s] && (src_lvl[s] == LVL_W'(l));
    end
    // lowest set index on this level
    always_comb begin
      lvl_idx[l] = '0;
      for (int s = N - 1; s >= 0; s--) begin
        if (lvl_mask[l][s]) lvl_idx[l] = IDX_W'(s);
      end
    end
  end

  // higher levels overwrite lower ones
  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_ok[l] && |lvl_mask[l]) begin
        win_any = 1'b1;
        win_idx = lvl_idx[l];
        win_lvl = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/irq_svc_tracker.sv
module irq_svc_tracker
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mark_en,
  input  logic [LVL_W-1:0]   mark_lvl,
  input  logic               pop,
  output logic [NUM_LVL-1:0] lvl_ok
);
  logic [NUM_LVL-1:0] svc_q, svc_d, pop_mask, mark_mask;

  always_comb begin
    pop_mask = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (svc_q[l]) begin
        pop_mask    = '0;
        pop_mask[l] = 1'b1;
      end
    end
  end

  assign mark_mask = mark_en ? (NUM_LVL'(1) << mark_lvl) : '0;
  assign svc_d     = (svc_q & ~(pop ? pop_mask : '0)) | mark_mask;

  // a level may be offered only if nothing at or above it is in service
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_ok
    assign lvl_ok[l] = ~|svc_d[NUM_LVL-1:l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = NUM_SRC_DEF,
  parameter int VEC_W   = VEC_W_DEF,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag_a,
  input  logic [NUM_SRC-1:0] flag_b,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] lvl_hi,
  input  logic               glb_en,
  input  logic               ack,
  input  logic               reti,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec
);
  logic [NUM_SRC-1:0]            pend;
  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
  logic [NUM_LVL-1:0]            lvl_ok;
  logic                          win_any;
  logic [IDX_W-1:0]              win_idx;
  logic [LVL_W-1:0]              win_lvl;

  logic                          req_q, req_d;
  logic [VEC_W-1:0]              vec_q, vec_d;
  logic [LVL_W-1:0]              win_lvl_q, win_lvl_d;
  logic                          load_en;

  irq_src_qualify #(.N(NUM_SRC), .WAKE_IDX(0)) u_qual (
    .flag_a (flag_a),
    .flag_b (flag_b),
    .src_en (src_en),
    .lvl_hi (lvl_hi),
    .glb_en (glb_en),
    .pend   (pend),
    .src_lvl(src_lvl)
  );

  irq_svc_tracker u_svc (
    .clk     (clk),
    .rst_n   (rst_n),
    .mark_en (ack & req_q),
    .mark_lvl(win_lvl_q),
    .pop     (reti),
    .lvl_ok  (lvl_ok)
  );

  irq_rank_select #(.N(NUM_SRC)) u_sel (
    .pend   (pend),
    .src_lvl(src_lvl),
    .lvl_ok (lvl_ok),
    .win_any(win_any),
    .win_idx(win_idx),
    .win_lvl(win_lvl)
  );

  always_comb begin
    req_d     = win_any;
    load_en   = win_any;
    vec_d     = VEC_W'(rank_vector(32'(win_idx)));
    win_lvl_d = win_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      vec_q     <= '0;
      win_lvl_q <= '0;
    end else begin
      req_q <= req_d;
      if (load_en) begin
        vec_q     <= vec_d;
        win_lvl_q <= win_lvl_d;
      end
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic             ack,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [1:0]       win_lvl_q
);
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      AST_RESET_IDLE: assert (!irq_req); // R1
    end
  end

  AST_REQ_NEEDS_GLB: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(glb_en)); // R2

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec >= VEC_W'(8'h03) && irq_vec <= VEC_W'(8'h63))); // R5

  AST_WAKE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec == VEC_W'(8'h33)) |-> (win_lvl_q == 2'd2)); // R6

  AST_NO_SAME_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> (!irq_req || win_lvl_q > $past(win_lvl_q))); // R9
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.VEC_W(VEC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .glb_en   (glb_en),
  .ack      (ack),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .win_lvl_q(win_lvl_q)
);

// File: tb/irq_level_arbiter_tb_top.sv
module irq_level_arbiter_tb_top;
  localparam int NS = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] flag_a, flag_b, src_en, lvl_hi;
  logic          glb_en, ack, reti;
  logic          irq_req;
  logic [7:0]    irq_vec;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  irq_level_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .flag_a(flag_a), .flag_b(flag_b),
    .src_en(src_en), .lvl_hi(lvl_hi), .glb_en(glb_en), .ack(ack),
    .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic int exp_vec(input int s);
    if (s == 0) return 51;
    if (s < 7)  return 3 + 8 * (s - 1);
    return 59 + 8 * (s - 7);
  endfunction

  function automatic int exp_lvl(input int s, input logic [NS-1:0] hi);
    return (s == 0) ? 2 : int'(hi[s]);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    flag_a = '0; flag_b = '0; src_en = '1; lvl_hi = '0;
    glb_en = 1'b1; ack = 1'b0; reti = 1'b0;
  endtask

  task automatic expect_req(input string tag, input int v);
    check(irq_req === 1'b1, {tag, " req"}, int'(irq_req), 1);
    check(irq_vec === 8'(v), {tag, " vec"}, int'(irq_vec), v);
  endtask

  task automatic expect_idle(input string tag);
    check(irq_req === 1'b0, {tag, " idle"}, int'(irq_req), 0);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; step(); reti = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clear_in();
    flag_a[3] = 1'b1;
    repeat (3) @(negedge clk);
    expect_idle("R1 in reset");
    rst_n = 1'b1;
    step();
    expect_req("R1 first low after reset", exp_vec(3));
    clear_in();
    step();

    // R2 gating and single-flag paths, R5 vector per source
    for (int s = 0; s < NS; s++) begin
      clear_in(); flag_a[s] = 1'b1; src_en[s] = 1'b0; step();
      expect_idle("R2 source disabled");
      clear_in(); flag_a[s] = 1'b1; glb_en = 1'b0; step();
      expect_idle("R2 global disabled");
      clear_in(); flag_b[s] = 1'b1; step();
      expect_req("R2 R5 second flag alone", exp_vec(s));
    end

    // R3 R4 R6 pair sweep over all level combinations
    for (int i = 0; i < NS; i++) begin
      for (int j = 0; j < NS; j++) begin
        for (int m = 0; m < 4; m++) begin
          int li, lj, best;
          clear_in();
          flag_a[i] = 1'b1;
          flag_b[j] = 1'b1;
          lvl_hi[i] = m[0];
          if (j != i) lvl_hi[j] = m[1];
          li = exp_lvl(i, lvl_hi);
          lj = exp_lvl(j, lvl_hi);
          if (li != lj) best = (li > lj) ? i : j;
          else          best = (i < j) ? i : j;
          step();
          expect_req("R3 R4 R6 pair", exp_vec(best));
        end
      end
    end

    // R7 re-evaluation before acknowledge
    clear_in(); step();
    flag_a[12] = 1'b1; step();
    expect_req("R7 single low", 8'h63);
    flag_a[10] = 1'b1; step();
    expect_req("R7 better replaces before ack", 8'h53);

    // R8 R9 R10 service nesting
    clear_in(); step();
    flag_a[1] = 1'b1; step();
    expect_req("R8 low offered", 8'h03);
    pulse_ack();
    expect_idle("R8 dropped after ack, flag still up");
    flag_a[1] = 1'b0;
    flag_a[5] = 1'b1; step();
    expect_idle("R9 low waits under low");
    flag_a[4] = 1'b1; lvl_hi[4] = 1'b1; step();
    expect_req("R9 high preempts low", 8'h1B);
    pulse_ack();
    flag_a[4] = 1'b0;
    expect_idle("R8 after high ack");
    flag_a[11] = 1'b1; lvl_hi[11] = 1'b1; step();
    expect_idle("R9 high waits under high");
    flag_a[0] = 1'b1; lvl_hi[0] = 1'b0; step();
    expect_req("R9 R6 wakeup preempts high", 8'h33);
    pulse_ack();
    flag_a[0] = 1'b0;
    expect_idle("R8 after top ack");
    pulse_reti();
    expect_idle("R10 top popped, high still in service");
    pulse_reti();
    expect_req("R10 high popped, waiting high offered", 8'h5B);
    pulse_ack();
    flag_a[11] = 1'b0;
    expect_idle("R8 after second high ack");
    pulse_reti();
    expect_idle("R10 high popped, low still in service");
    pulse_reti();
    expect_req("R10 low popped, waiting low offered", 8'h23);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule